// File: doc/BRIEF.md
# Power Control Register Unit

This block is the software-visible face of a chip's power manager. It holds the control word that selects how the chip behaves in deep sleep: stop or standby, and whether the regulator runs in low-power mode during stop. The same word enables the supply-voltage monitor and picks one of its eight thresholds, powers the flash down during stop, and selects the regulator voltage scale. A second word, the control/status register, holds the wakeup-pin enable, the backup-regulator enable and five sticky or live status flags. The analog parts (supply comparator, backup regulator, wakeup pin, real-time-clock wake source) appear only as plain input signals.

The block also gates writes into the backup domain. A backup-domain register asks for a write on `bkdom_wr_req`, and `bkdom_wr_ok` grants it only while the access-enable bit is set. After every reset that bit is clear, so the backup domain starts out locked.

The flags live in three reset domains. A backup-domain reset (`bkp_rst_n`) clears everything. A power-on reset (`por_n`) leaves the backup-regulator state alone. A system reset (`sys_rst_n`) also leaves the wakeup and standby flags alone. A standby exit, signalled by a one-cycle pulse on `standby_wake`, returns the control word to its reset value and sets the standby flag. The register port is a plain single-cycle interface with no back-pressure. A write with `bus_sel` and `bus_we` high takes effect at the next clock edge. Read data is combinational from the current address.

Top module: `pwrctl_top`

## Requirements
- R1: After all resets, the control register (address 0x0) reads 0x0000_4000 and the control/status register (address 0x4) reads 0x0000_4000. Any other address reads 0, and writes to it change nothing.
- R2: Control bits are read/write and each drives its output: bit 0 `stop_lp_reg`, bit 1 `sleep_standby`, bit 4 `mon_en`, bits 7:5 `mon_level`, bit 8 the backup access enable, bit 9 `flash_pd_stop`, bit 14 `vscale1`. All other control bits read 0.
- R3: A write changes only the bits whose `bus_wmask` bit is 1. A threshold update with mask 0xE0 leaves every other control bit as it was.
- R4: Writing 1 to control bit 2 clears the wakeup flag (status bit 0), and writing 1 to control bit 3 clears the standby flag (status bit 1). Writing 0 there has no effect, and both bits read back as 0.
- R5: The wakeup flag sets at the clock edge after a wake event. A wake event is a rising `wkup_pin` while the pin enable (status bit 8) is 1, a `rtc_wake` pulse, or setting the pin enable while the pin is already high. The pin is ignored while its enable is 0. If a set and a clear fall in the same cycle, the set wins.
- R6: A `standby_wake` pulse sets the standby flag, returns the control register to 0x0000_4000 and forces the monitor flag to 0. The wakeup flag and the pin enable are kept.
- R7: The monitor flag (status bit 2) equals the `supply_low` value of the previous cycle while `mon_en` is 1, and is 0 while `mon_en` is 0.
- R8: The backup-regulator enable (status bit 9, output `bkreg_en`) and its ready flag (status bit 3, the registered AND of the enable and `bkreg_rdy`) survive power-on and system resets. Only `bkp_rst_n` clears them.
- R9: The voltage-scale-ready flag (status bit 14) reads 0 from the write that changes `vscale1` until VS_SETTLE+1 clock edges after that write, then reads 1.
- R10: The wakeup and standby flags survive a system reset and are cleared by a power-on reset.
- R11: Status bits 0 to 3 and 14 are read-only, and writes to them are ignored. Bits 8 and 9 are read/write. All other status bits read 0.
- R12: `bkdom_wr_ok` is 1 exactly when `bkdom_wr_req` is 1 and control bit 8 is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bkp_rst_n | input | 1 | Backup-domain reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write enable |
| bus_rdata | output | 32 | Read data (combinational) |
| wkup_pin | input | 1 | Wakeup pin level |
| rtc_wake | input | 1 | Wake pulse from the real-time clock |
| standby_wake | input | 1 | One-cycle pulse on exit from standby |
| supply_low | input | 1 | Supply comparator: 1 = below threshold |
| bkreg_rdy | input | 1 | Backup regulator ready from analog |
| bkdom_wr_req | input | 1 | Backup-domain write request |
| bkdom_wr_ok | output | 1 | Backup-domain write granted |
| mon_en | output | 1 | Supply monitor enable |
| mon_level | output | 3 | Supply monitor threshold select |
| flash_pd_stop | output | 1 | Power down flash in stop |
| vscale1 | output | 1 | Regulator voltage scale 1 select |
| sleep_standby | output | 1 | Deep sleep enters standby instead of stop |
| stop_lp_reg | output | 1 | Regulator low-power during stop |
| bkreg_en | output | 1 | Backup regulator enable |

## Verification
The bench targets the reset domains. It checks that the wakeup and standby flags survive a system reset but not a power-on reset, and that the backup-regulator state survives both. A design with a single reset would lose these flags at the wrong time. It also targets the wakeup-edge logic: enabling the pin while it is already high must count as a wake event, and a set arriving in the same cycle as a clear must win. An edge detector fed from the raw pin would miss the first case, and a clear-first priority would drop an event. Finally, it checks the masked threshold write, where a design that stored the whole word would disturb the other control bits, and it checks the exact edge at which voltage-scale-ready returns, which catches an off-by-one counter.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;
  localparam int DW = 32;

  // register offsets (byte addresses)
  localparam int OFS_CTL  = 0;
  localparam int OFS_STAT = 4;

  // control word bit positions
  localparam int C_LPREG  = 0;
  localparam int C_STBY   = 1;
  localparam int C_CLRWU  = 2;
  localparam int C_CLRSB  = 3;
  localparam int C_MONEN  = 4;
  localparam int C_LVL    = 5;
  localparam int LVL_W    = 3;
  localparam int C_BKWE   = 8;
  localparam int C_FLPD   = 9;
  localparam int C_VS1    = 14;

  // status word bit positions
  localparam int S_WU     = 0;
  localparam int S_SB     = 1;
  localparam int S_MON    = 2;
  localparam int S_BRDY   = 3;
  localparam int S_PINEN  = 8;
  localparam int S_BREN   = 9;
  localparam int S_VSRDY  = 14;

  // bits of the control word that hold state
  localparam logic [DW-1:0] CTL_RW =
      (DW'(1) << C_LPREG) | (DW'(1) << C_STBY) | (DW'(1) << C_MONEN) |
      (DW'(7) << C_LVL)   | (DW'(1) << C_BKWE) | (DW'(1) << C_FLPD)  |
      (DW'(1) << C_VS1);
  localparam logic [DW-1:0] CTL_RST = DW'(1) << C_VS1;

  typedef struct packed {
    logic             vs1;
    logic             flpd;
    logic             bkwe;
    logic [LVL_W-1:0] lvl;
    logic             monen;
    logic             stby;
    logic             lpreg;
  } ctl_t;
endpackage

// File: rtl/pwrctl_ctl_reg.sv
module pwrctl_ctl_reg
  import pwrctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          stat_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] wmask,
  input  logic          standby_wake,
  output ctl_t          ctl,
  output logic [DW-1:0] ctl_image,
  output logic          clr_wu,
  output logic          clr_sb,
  output logic          pin_en
);
  logic [DW-1:0] cr_q;
  logic          pin_en_q;
  logic [DW-1:0] wm_eff;

  assign wm_eff = wmask & CTL_RW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q <= CTL_RST;
    end else if (standby_wake) begin
      cr_q <= CTL_RST;
    end else if (ctl_wr) begin
      cr_q <= (cr_q & ~wm_eff) | (wdata & wm_eff);
    end
  end

  // wakeup pin enable: core domain, kept across standby exit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_en_q <= 1'b0;
    end else if (stat_wr && wmask[S_PINEN]) begin
      pin_en_q <= wdata[S_PINEN];
    end
  end

  assign clr_wu    = ctl_wr & wmask[C_CLRWU] & wdata[C_CLRWU];
  assign clr_sb    = ctl_wr & wmask[C_CLRSB] & wdata[C_CLRSB];
  assign pin_en    = pin_en_q;
  assign ctl_image = cr_q;

  assign ctl.vs1   = cr_q[C_VS1];
  assign ctl.flpd  = cr_q[C_FLPD];
  assign ctl.bkwe  = cr_q[C_BKWE];
  assign ctl.lvl   = cr_q[C_LVL +: LVL_W];
  assign ctl.monen = cr_q[C_MONEN];
  assign ctl.stby  = cr_q[C_STBY];
  assign ctl.lpreg = cr_q[C_LPREG];

  AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !standby_wake) |=> ((cr_q & ~$past(wmask)) == ($past(cr_q) & ~$past(wmask)))); // R3

  AST_STBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    standby_wake |=> (cr_q == CTL_RST)); // R6
endmodule

// File: rtl/pwrctl_flags.sv
module pwrctl_flags
  import pwrctl_pkg::*;
(
  input  logic          clk,
  input  logic          por_n,
  input  logic          core_rst_n,
  input  logic          bkp_rst_n,
  input  logic          wkup_pin,
  input  logic          pin_en,
  input  logic          rtc_wake,
  input  logic          standby_wake,
  input  logic          clr_wu,
  input  logic          clr_sb,
  input  logic          mon_en,
  input  logic          supply_low,
  input  logic          bre_wr,
  input  logic          bre_wdata,
  input  logic          bkreg_rdy,
  output logic          wu_flag,
  output logic          sb_flag,
  output logic          mon_flag,
  output logic          brdy_flag,
  output logic          bre
);
  logic pin_gated;
  logic pin_q;
  logic wake_evt;

  assign pin_gated = wkup_pin & pin_en;
  assign wake_evt  = (pin_gated & ~pin_q) | rtc_wake;

  // gated pin history; enabling while high looks like an edge
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) pin_q <= 1'b0;
    else             pin_q <= pin_gated;
  end

  // sticky flags: power-on domain, set wins over clear
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wu_flag <= 1'b0;
      sb_flag <= 1'b0;
    end else begin
      if (wake_evt)          wu_flag <= 1'b1;
      else if (clr_wu)       wu_flag <= 1'b0;
      if (standby_wake)      sb_flag <= 1'b1;
      else if (clr_sb)       sb_flag <= 1'b0;
    end
  end

  // supply monitor output: core domain, stopped by standby
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)       mon_flag <= 1'b0;
    else if (standby_wake) mon_flag <= 1'b0;
    else                   mon_flag <= mon_en & supply_low;
  end

  // backup regulator: backup domain only
  always_ff @(posedge clk or negedge bkp_rst_n) begin
    if (!bkp_rst_n) begin
      bre       <= 1'b0;
      brdy_flag <= 1'b0;
    end else begin
      if (bre_wr) bre <= bre_wdata;
      brdy_flag <= bre & bkreg_rdy;
    end
  end

  AST_WU_SETS: assert property (@(posedge clk) disable iff (!por_n)
    wake_evt |=> wu_flag); // R5

  AST_SB_SETS: assert property (@(posedge clk) disable iff (!por_n)
    standby_wake |=> sb_flag); // R6

  AST_MON_OFF: assert property (@(posedge clk) disable iff (!core_rst_n)
    !mon_en |=> !mon_flag); // R7

  AST_BRDY_NEEDS_EN: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    !bre |=> !brdy_flag); // R8
endmodule

// File: rtl/pwrctl_vs_timer.sv
module pwrctl_vs_timer #(
  parameter int SETTLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_in,
  output logic ready
);
  localparam int CW = $clog2(SETTLE + 1);

  logic          vs_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q <= 1'b1;
      cnt  <= '0;
    end else if (vs_in != vs_q) begin
      vs_q <= vs_in;
      cnt  <= CW'(SETTLE);
    end else if (cnt != '0) begin
      cnt  <= cnt - 1'b1;
    end
  end

  assign ready = (cnt == '0) && (vs_in == vs_q);

  AST_VS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_in != $past(vs_in)) |-> !ready); // R9
endmodule

// File: rtl/pwrctl_top.sv
module pwrctl_top
  import pwrctl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int VS_SETTLE = 8
) (
  input  logic              clk,
  input  logic              bkp_rst_n,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_wmask,
  output logic [31:0]       bus_rdata,
  input  logic              wkup_pin,
  input  logic              rtc_wake,
  input  logic              standby_wake,
  input  logic              supply_low,
  input  logic              bkreg_rdy,
  input  logic              bkdom_wr_req,
  output logic              bkdom_wr_ok,
  output logic              mon_en,
  output logic [2:0]        mon_level,
  output logic              flash_pd_stop,
  output logic              vscale1,
  output logic              sleep_standby,
  output logic              stop_lp_reg,
  output logic              bkreg_en
);
  logic          core_rst_n;
  logic          hit_ctl, hit_stat;
  logic          ctl_wr, stat_wr;
  ctl_t          ctl;
  logic [DW-1:0] ctl_image;
  logic [DW-1:0] stat_image;
  logic          clr_wu, clr_sb, pin_en;
  logic          wu_flag, sb_flag, mon_flag, brdy_flag, bre;
  logic          vs_ready;

  assign core_rst_n = por_n & sys_rst_n;

  assign hit_ctl  = (bus_addr == ADDR_W'(OFS_CTL));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign ctl_wr   = bus_sel & bus_we & hit_ctl;
  assign stat_wr  = bus_sel & bus_we & hit_stat;

  pwrctl_ctl_reg u_ctl (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .ctl_wr       (ctl_wr),
    .stat_wr      (stat_wr),
    .wdata        (bus_wdata),
    .wmask        (bus_wmask),
    .standby_wake (standby_wake),
    .ctl          (ctl),
    .ctl_image    (ctl_image),
    .clr_wu       (clr_wu),
    .clr_sb       (clr_sb),
    .pin_en       (pin_en)
  );

  pwrctl_flags u_flags (
    .clk          (clk),
    .por_n        (por_n),
    .core_rst_n   (core_rst_n),
    .bkp_rst_n    (bkp_rst_n),
    .wkup_pin     (wkup_pin),
    .pin_en       (pin_en),
    .rtc_wake     (rtc_wake),
    .standby_wake (standby_wake),
    .clr_wu       (clr_wu),
    .clr_sb       (clr_sb),
    .mon_en       (ctl.monen),
    .supply_low   (supply_low),
    .bre_wr       (stat_wr & bus_wmask[S_BREN]),
    .bre_wdata    (bus_wdata[S_BREN]),
    .bkreg_rdy    (bkreg_rdy),
    .wu_flag      (wu_flag),
    .sb_flag      (sb_flag),
    .mon_flag     (mon_flag),
    .brdy_flag    (brdy_flag),
    .bre          (bre)
  );

  pwrctl_vs_timer #(.SETTLE(VS_SETTLE)) u_vs (
    .clk   (clk),
    .rst_n (core_rst_n),
    .vs_in (ctl.vs1),
    .ready (vs_ready)
  );

  always_comb begin
    stat_image          = '0;
    stat_image[S_WU]    = wu_flag;
    stat_image[S_SB]    = sb_flag;
    stat_image[S_MON]   = mon_flag;
    stat_image[S_BRDY]  = brdy_flag;
    stat_image[S_PINEN] = pin_en;
    stat_image[S_BREN]  = bre;
    stat_image[S_VSRDY] = vs_ready;
  end

  always_comb begin
    if (hit_ctl)       bus_rdata = ctl_image;
    else if (hit_stat) bus_rdata = stat_image;
    else               bus_rdata = '0;
  end

  assign bkdom_wr_ok   = bkdom_wr_req & ctl.bkwe;
  assign mon_en        = ctl.monen;
  assign mon_level     = ctl.lvl;
  assign flash_pd_stop = ctl.flpd;
  assign vscale1       = ctl.vs1;
  assign sleep_standby = ctl.stby;
  assign stop_lp_reg   = ctl.lpreg;
  assign bkreg_en      = bre;

  AST_CLR_READ_ZERO: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_sel && hit_ctl) |-> (bus_rdata[C_CLRSB:C_CLRWU] == 2'b00)); // R4

  AST_STRAY_ADDR_ZERO: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!hit_ctl && !hit_stat) |-> (bus_rdata == '0)); // R1

  AST_GATE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!core_rst_n)
    bkdom_wr_ok |-> bkdom_wr_req); // R12
endmodule

// File: tb/pwrctl_top_bench.sv
module pwrctl_top_bench;
  localparam int AW     = 4;
  localparam int SETTLE = 8;

  logic          clk = 1'b0;
  logic          bkp_rst_n = 1'b0, por_n = 1'b0, sys_rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0, bus_wmask = '0;
  logic [31:0]   bus_rdata;
  logic          wkup_pin = 1'b0, rtc_wake = 1'b0, standby_wake = 1'b0;
  logic          supply_low = 1'b0, bkreg_rdy = 1'b0, bkdom_wr_req = 1'b0;
  logic          bkdom_wr_ok, mon_en, flash_pd_stop, vscale1;
  logic          sleep_standby, stop_lp_reg, bkreg_en;
  logic [2:0]    mon_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwrctl_top #(.ADDR_W(AW), .VS_SETTLE(SETTLE)) u_pwrctl_top (
    .clk(clk), .bkp_rst_n(bkp_rst_n), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
    .wkup_pin(wkup_pin), .rtc_wake(rtc_wake), .standby_wake(standby_wake),
    .supply_low(supply_low), .bkreg_rdy(bkreg_rdy),
    .bkdom_wr_req(bkdom_wr_req), .bkdom_wr_ok(bkdom_wr_ok),
    .mon_en(mon_en), .mon_level(mon_level), .flash_pd_stop(flash_pd_stop),
    .vscale1(vscale1), .sleep_standby(sleep_standby),
    .stop_lp_reg(stop_lp_reg), .bkreg_en(bkreg_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [31:0] m);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wmask = m;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wmask = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic full_reset();
    bkp_rst_n = 1'b0; por_n = 1'b0; sys_rst_n = 1'b0;
    wkup_pin = 1'b0; rtc_wake = 1'b0; standby_wake = 1'b0;
    supply_low = 1'b0; bkreg_rdy = 1'b0; bkdom_wr_req = 1'b0;
    tick(2);
    bkp_rst_n = 1'b1; por_n = 1'b1; sys_rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse_rtc();
    rtc_wake = 1'b1; tick(1); rtc_wake = 1'b0;
  endtask

  task automatic pulse_stby();
    standby_wake = 1'b1; tick(1); standby_wake = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    full_reset();
    rd(4'h0, d); chk("R1 ctl reset", d, 32'h4000);
    rd(4'h4, d); chk("R1 stat reset", d, 32'h4000);
    chk("R1 mon_en reset", {31'b0, mon_en}, 32'h0);
    chk("R1 vscale1 reset", {31'b0, vscale1}, 32'h1);
  endtask

  task automatic t_ctl_fields();
    logic [31:0] d;
    full_reset();
    wr(4'h0, 32'hFFFF_FFF3, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R2 ctl rw bits", d, 32'h43F3);
    chk("R2 outputs", {24'b0, stop_lp_reg, sleep_standby, mon_en, mon_level, flash_pd_stop, vscale1},
        32'b1111_1111);
    wr(4'h0, 32'h0000_0000, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R2 ctl cleared", d, 32'h0);
  endtask

  task automatic t_masked();
    logic [31:0] d;
    full_reset();
    wr(4'h0, 32'h0000_0311, 32'h0000_FFFF & ~32'h4000);
    wr(4'h0, 32'hFFFF_FFBF, 32'h0000_00E0);
    rd(4'h0, d); chk("R3 threshold only", d, 32'h43B1);
    chk("R3 level out", {29'b0, mon_level}, 32'h5);
    wr(4'h0, 32'h0, 32'h0);
    rd(4'h0, d); chk("R3 zero mask", d, 32'h43B1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    full_reset();
    pulse_rtc();
    pulse_stby();
    rd(4'h4, d); chk("R4 flags set", d & 32'h3, 32'h3);
    wr(4'h0, 32'h0, 32'hC);
    rd(4'h4, d); chk("R4 zero no effect", d & 32'h3, 32'h3);
    wr(4'h0, 32'h4, 32'h4);
    rd(4'h4, d); chk("R4 clear wakeup", d & 32'h3, 32'h2);
    rd(4'h0, d); chk("R4 clear bits read 0", d & 32'hC, 32'h0);
    wr(4'h0, 32'h8, 32'h8);
    rd(4'h4, d); chk("R4 clear standby", d & 32'h3, 32'h0);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    full_reset();
    wkup_pin = 1'b1; tick(2);
    rd(4'h4, d); chk("R5 pin ignored when disabled", d & 32'h1, 32'h0);
    wr(4'h4, 32'h100, 32'h100);
    rd(4'h4, d); chk("R5 not yet set", d & 32'h1, 32'h0);
    tick(1);
    rd(4'h4, d); chk("R5 enable while high", d & 32'h1, 32'h1);
    wr(4'h0, 32'h4, 32'h4); tick(2);
    rd(4'h4, d); chk("R5 no new edge", d & 32'h1, 32'h0);
    wkup_pin = 1'b0; tick(1); wkup_pin = 1'b1; tick(1);
    rd(4'h4, d); chk("R5 rising pin", d & 32'h1, 32'h1);
    wr(4'h0, 32'h4, 32'h4);
    rtc_wake = 1'b1;
    wr(4'h0, 32'h4, 32'h4);
    rtc_wake = 1'b0;
    rd(4'h4, d); chk("R5 set beats clear", d & 32'h1, 32'h1);
  endtask

  task automatic t_standby();
    logic [31:0] d;
    full_reset();
    supply_low = 1'b1;
    wr(4'h0, 32'h4310, 32'hFFFF_FFFF);
    wr(4'h4, 32'h100, 32'h100);
    rd(4'h4, d); chk("R6 monitor before standby", d & 32'h4, 32'h4);
    pulse_stby();
    rd(4'h0, d); chk("R6 ctl back to reset", d, 32'h4000);
    rd(4'h4, d); chk("R6 stat after standby", d, 32'h4102);
    supply_low = 1'b0;
  endtask

  task automatic t_pvdo();
    logic [31:0] d;
    full_reset();
    supply_low = 1'b1; tick(2);
    rd(4'h4, d); chk("R7 disabled reads 0", d & 32'h4, 32'h0);
    wr(4'h0, 32'h4010, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R7 one cycle lag", d & 32'h4, 32'h0);
    tick(1);
    rd(4'h4, d); chk("R7 follows low", d & 32'h4, 32'h4);
    supply_low = 1'b0; tick(1);
    rd(4'h4, d); chk("R7 follows high", d & 32'h4, 32'h0);
  endtask

  task automatic t_domains();
    logic [31:0] d;
    full_reset();
    bkreg_rdy = 1'b1;
    wr(4'h4, 32'h200, 32'h200);
    tick(1);
    pulse_rtc();
    rd(4'h4, d); chk("R8 ready set", d, 32'h4209);
    sys_rst_n = 1'b0; tick(1); sys_rst_n = 1'b1; tick(1);
    rd(4'h4, d); chk("R10 sys reset keeps flags", d, 32'h4209);
    por_n = 1'b0; tick(1); por_n = 1'b1; tick(1);
    rd(4'h4, d); chk("R8 R10 por keeps backup", d, 32'h4208);
    chk("R8 bkreg_en out", {31'b0, bkreg_en}, 32'h1);
    bkp_rst_n = 1'b0; tick(1); bkp_rst_n = 1'b1; tick(1);
    rd(4'h4, d); chk("R8 backup reset clears", d, 32'h4000);
  endtask

  task automatic t_vs();
    logic [31:0] d;
    full_reset();
    wr(4'h0, 32'h0, 32'h4000);
    rd(4'h4, d); chk("R9 drop after write", d & 32'h4000, 32'h0);
    tick(SETTLE);
    rd(4'h4, d); chk("R9 still settling", d & 32'h4000, 32'h0);
    tick(1);
    rd(4'h4, d); chk("R9 ready again", d & 32'h4000, 32'h4000);
  endtask

  task automatic t_stat_ro();
    logic [31:0] d;
    full_reset();
    wr(4'h4, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R11 status read-only", d, 32'h4300);
  endtask

  task automatic t_gate();
    full_reset();
    bkdom_wr_req = 1'b1; #1;
    chk("R12 locked after reset", {31'b0, bkdom_wr_ok}, 32'h0);
    wr(4'h0, 32'h4100, 32'hFFFF_FFFF); #1;
    chk("R12 granted", {31'b0, bkdom_wr_ok}, 32'h1);
    bkdom_wr_req = 1'b0; #1;
    chk("R12 no request", {31'b0, bkdom_wr_ok}, 32'h0);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    full_reset();
    wr(4'h8, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R1 stray write ctl", d, 32'h4000);
    rd(4'h4, d); chk("R1 stray write stat", d, 32'h4000);
    rd(4'h8, d); chk("R1 stray read", d, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ctl_fields();
    t_masked();
    t_clear();
    t_wake();
    t_standby();
    t_pvdo();
    t_domains();
    t_vs();
    t_stat_ro();
    t_gate();
    t_addr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule